// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This control block accepts a request carrying an application vector length `n` of any size and splits it into a series of vector operations, none longer than the maximum hardware vector length (64 elements by default). For every piece it presents the length that the vector length register must hold, the index of the first element that the piece covers, and a one-cycle start strobe. It then waits for the vector datapath to report completion before it launches the next piece.

The piece that is not a whole multiple of the maximum length goes first. Every piece after it is full length. When `n` is an exact multiple, no zero-length piece is issued, and the first piece is already full. When `n` is zero, no piece is issued and the sequence completes at once. A single-cycle completion pulse marks the end of each request, and the block then returns to idle.

Top module: `strip_seq`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and `piece_start`, `piece_last` and `seq_done` are 0.
- R2: A request is taken when `req_valid` is 1 while `req_ready` is 1. For n > 0, `piece_start` is 1 in the cycle after the request is taken. While a request is being processed, `req_ready` is 0 and `req_valid` is ignored.
- R3: The first piece has `piece_vl` = n mod 64 when that value is nonzero.
- R4: Every piece after the first has `piece_vl` = 64.
- R5: When n is a nonzero multiple of 64, no zero-length piece is issued. The first piece has `piece_vl` = 64, and there are exactly n/64 pieces.
- R6: Each piece's `piece_base` equals the sum of the `piece_vl` values of all earlier pieces of the same request. The first piece has base 0.
- R7: When n = 0, no piece is issued, and `seq_done` is 1 in the cycle after the request is taken.
- R8: A following piece starts only in the cycle after `piece_done` is sampled at 1 while the block waits for the current piece. A `piece_done` that arrives in the same cycle as `piece_start` is ignored.
- R9: `piece_last` is 1 together with the `piece_start` of the final piece of a request, and is 0 on every other start.
- R10: `seq_done` is a single-cycle pulse in the cycle after the final piece's `piece_done` is sampled. In the cycle after the pulse, `req_ready` is 1.
- R11: `piece_start` lasts exactly one cycle. `piece_vl` and `piece_base` stay stable from a start until the next start or the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A new request is offered |
| req_len | input | LEN_W | Application vector length n of the request |
| req_ready | output | 1 | Idle and able to take a request |
| piece_start | output | 1 | One-cycle strobe that launches a piece |
| piece_vl | output | VL_W | Vector length register value for the current piece |
| piece_base | output | LEN_W | First element index of the current piece |
| piece_last | output | 1 | The starting piece is the last of the request |
| piece_done | input | 1 | Datapath reports that the current piece has finished |
| seq_done | output | 1 | One-cycle pulse: the request is complete |

## Verification
The following rules are checked by assertions on every cycle:
- Every issued length lies between 1 and 64.
- Any piece with a nonzero base is full length.
- Starts are single-cycle pulses.
- A start follows only an accepted request or a sampled completion.
- The length and base hold still while a piece runs.
- The completion pulse returns the block to idle.

Other properties need whole request scenarios in the bench and cannot be seen on a single cycle:
- The exact remainder-first order of piece lengths.
- The running sum of bases.
- Where the last-piece flag falls.
- Skipping the empty first piece for exact multiples.
- The immediate finish for n = 0.
- Ignoring an early done or a request that arrives while busy.

// File: rtl/strip_pkg.sv
package strip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  // Length of the leading piece: the remainder of n over the maximum length,
  // or a full piece when the remainder is zero (only meaningful for n > 0).
  function automatic int unsigned lead_len(int unsigned n, int unsigned maxvl);
    int unsigned r;
    r = n % maxvl;
    return (r == 0) ? maxvl : r;
  endfunction

  // Number of pieces a request of length n breaks into.
  function automatic int unsigned piece_count(int unsigned n, int unsigned maxvl);
    return (n / maxvl) + ((n % maxvl) != 0 ? 1 : 0);
  endfunction

endpackage

// File: rtl/strip_plan.sv
module strip_plan #(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic [LEN_W-1:0] n,
  output logic [VL_W-1:0]  first_vl,
  output logic             is_empty
);
  import strip_pkg::*;

  always_comb begin
    first_vl = VL_W'(lead_len(32'(n), MAX_VL));
    is_empty = (n == '0);
  end

endmodule

// File: rtl/strip_track.sv
module strip_track #(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] n,
  input  logic [VL_W-1:0]  first_vl,
  input  logic             advance,
  output logic [LEN_W-1:0] base,
  output logic [VL_W-1:0]  vl,
  output logic             last_piece
);
  localparam logic [VL_W-1:0] FULL_VL = VL_W'(MAX_VL);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      base   <= '0;
      vl     <= '0;
    end else if (load) begin
      remain <= n;
      base   <= '0;
      vl     <= first_vl;
    end else if (advance) begin
      remain <= remain - LEN_W'(vl);
      base   <= base + LEN_W'(vl);
      vl     <= FULL_VL;
    end
  end

  assign last_piece = (remain == LEN_W'(vl));

endmodule

// File: rtl/strip_fsm.sv
module strip_fsm
  import strip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic is_empty,
  input  logic piece_done,
  input  logic last_piece,
  output logic req_ready,
  output logic piece_start,
  output logic seq_done,
  output logic accept_req,
  output logic load,
  output logic done_taken
);
  seq_state_e state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req_valid) state_nx = is_empty ? ST_FIN : ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  if (piece_done) state_nx = last_piece ? ST_FIN : ST_ISSUE;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign req_ready   = (state == ST_IDLE);
  assign piece_start = (state == ST_ISSUE);
  assign seq_done    = (state == ST_FIN);
  assign accept_req  = req_ready && req_valid;
  assign load        = accept_req && !is_empty;
  assign done_taken  = (state == ST_WAIT) && piece_done;

endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             piece_start,
  output logic [VL_W-1:0]  piece_vl,
  output logic [LEN_W-1:0] piece_base,
  output logic             piece_last,
  input  logic             piece_done,
  output logic             seq_done
);
  // Named internal events, visible to the bound checker.
  logic            accept_req;
  logic            done_taken;
  logic            load;
  logic            is_empty;
  logic            last_piece;
  logic [VL_W-1:0] first_vl;

  strip_plan #(.LEN_W(LEN_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_plan (
    .n        (req_len),
    .first_vl (first_vl),
    .is_empty (is_empty)
  );

  strip_track #(.LEN_W(LEN_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .n          (req_len),
    .first_vl   (first_vl),
    .advance    (done_taken),
    .base       (piece_base),
    .vl         (piece_vl),
    .last_piece (last_piece)
  );

  strip_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .is_empty    (is_empty),
    .piece_done  (piece_done),
    .last_piece  (last_piece),
    .req_ready   (req_ready),
    .piece_start (piece_start),
    .seq_done    (seq_done),
    .accept_req  (accept_req),
    .load        (load),
    .done_taken  (done_taken)
  );

  assign piece_last = piece_start && last_piece;

endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             piece_start,
  input logic [VL_W-1:0]  piece_vl,
  input logic [LEN_W-1:0] piece_base,
  input logic             seq_done,
  input logic             accept_req,
  input logic             done_taken
);
  localparam logic [VL_W-1:0] FULL_VL = VL_W'(MAX_VL);

  // R3
  vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    piece_start |-> (piece_vl != '0) && (piece_vl <= FULL_VL));

  // R4
  later_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (piece_start && piece_base != '0) |-> piece_vl == FULL_VL);

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    piece_start |=> !piece_start);

  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    piece_start |-> ($past(done_taken) || $past(accept_req)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (req_ready && !seq_done));

  // R11
  hold_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !piece_start && !seq_done) |-> $stable(piece_vl));

  // R11
  hold_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !piece_start && !seq_done) |-> $stable(piece_base));

endmodule

bind strip_seq strip_seq_chk #(.LEN_W(LEN_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .piece_start (piece_start),
  .piece_vl    (piece_vl),
  .piece_base  (piece_base),
  .seq_done    (seq_done),
  .accept_req  (accept_req),
  .done_taken  (done_taken)
);

// File: tb/strip_seq_test.sv
module strip_seq_test;
  localparam int LEN_W  = 16;
  localparam int MAX_VL = 64;
  localparam int VL_W   = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_ready;
  logic             piece_start;
  logic [VL_W-1:0]  piece_vl;
  logic [LEN_W-1:0] piece_base;
  logic             piece_last;
  logic             piece_done = 1'b0;
  logic             seq_done;

  always #5 clk = ~clk;

  strip_seq #(.LEN_W(LEN_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .piece_start(piece_start), .piece_vl(piece_vl),
    .piece_base(piece_base), .piece_last(piece_last), .piece_done(piece_done),
    .seq_done(seq_done)
  );

  typedef struct {int vl; int base; bit last;} exp_t;
  exp_t exp_q[$];
  exp_t cur;
  int   tests = 0;
  int   fails = 0;
  int   cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver side: expected pieces, remainder first then full ones.
  task automatic push_expected(int n, output int cnt);
    int len = n % MAX_VL;
    int b = 0;
    cnt = 0;
    if (len == 0) len = MAX_VL;
    while (b < n) begin
      exp_q.push_back('{vl: len, base: b, last: (b + len == n)});
      b += len;
      len = MAX_VL;
      cnt++;
    end
  endtask

  // Monitor: every start is compared with the next expected piece.
  always @(negedge clk) begin
    if (rst_n && piece_start) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected piece", int'(piece_vl), 0);
      end else begin
        cur = exp_q.pop_front();
        check(int'(piece_vl) == cur.vl, "R3/R4/R5", "piece length", int'(piece_vl), cur.vl);
        check(int'(piece_base) == cur.base, "R6", "piece base", int'(piece_base), cur.base);
        check(piece_last == cur.last, "R9", "last flag", int'(piece_last), int'(cur.last));
      end
    end
  end

  task automatic run_job(int n, int lat, bit early, bit poke);
    int cnt;
    while (!req_ready) @(negedge clk);
    push_expected(n, cnt);
    req_len   = LEN_W'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(seq_done == 1'b1, "R7", "immediate finish", int'(seq_done), 1);
      check(piece_start == 1'b0, "R7", "no piece for n=0", int'(piece_start), 0);
      @(negedge clk);
      check(!seq_done && req_ready, "R10", "idle after finish", int'(req_ready), 1);
      return;
    end
    check(piece_start == 1'b1, "R2", "start after request", int'(piece_start), 1);
    for (int k = 0; k < cnt; k++) begin
      if (early) piece_done = 1'b1;
      @(negedge clk);
      piece_done = 1'b0;
      check(piece_start == 1'b0, "R11", "start is one cycle", int'(piece_start), 0);
      if (poke && k == 0) begin
        check(req_ready == 1'b0, "R2", "busy not ready", int'(req_ready), 0);
        req_len   = LEN_W'(5);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
      repeat (lat) @(negedge clk);
      check(!piece_start && !seq_done, "R8", "no issue before done", int'(piece_start), 0);
      piece_done = 1'b1;
      @(negedge clk);
      piece_done = 1'b0;
      if (k < cnt - 1) begin
        check(piece_start == 1'b1, "R8", "next start after done", int'(piece_start), 1);
      end else begin
        check(seq_done == 1'b1, "R10", "finish after last done", int'(seq_done), 1);
        check(piece_start == 1'b0, "R10", "no extra piece", int'(piece_start), 0);
      end
    end
    @(negedge clk);
    check(!seq_done && req_ready, "R10", "single pulse then ready", int'(seq_done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !piece_start && !piece_last && !seq_done, "R1", "in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !piece_start && !seq_done, "R1", "after reset", int'(piece_start), 0);
    run_job(0, 1, 1'b0, 1'b0);       // R7
    run_job(1, 1, 1'b0, 1'b0);       // R3 single short piece
    run_job(64, 2, 1'b0, 1'b0);      // R5 one full piece
    run_job(65, 1, 1'b0, 1'b0);      // R3 R4
    run_job(128, 3, 1'b0, 1'b0);     // R5 two full pieces
    run_job(200, 1, 1'b1, 1'b0);     // R8 early done ignored
    run_job(63, 2, 1'b0, 1'b1);      // R2 request while busy ignored
    run_job(300, 4, 1'b1, 1'b1);     // R6 R9
    run_job(0, 1, 1'b0, 1'b0);       // R7 again
    run_job(65535, 1, 1'b0, 1'b0);   // largest length
    check(exp_q.size() == 0, "R6", "all expected pieces seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule